// File: doc/BRIEF.md
# Rotate-Mask-Merge Shift Unit

This unit executes a family of 32-bit shift operations built from three steps. First it rotates a source word by a 5-bit amount, to the left or to the right. Next it builds a composite mask by ANDing a shift-mask with an end-mask. Finally it writes the masked rotated word in one of three ways. Zero-fill clears every bit outside the mask. Keep takes the bits outside the mask from the old destination word. Sign-replicate fills each bit outside the mask from the bit just below it, so the fill cascades upward. By choosing the masks and the fill style, one datapath gives logical shifts, arithmetic shifts, rotates, field extracts, field inserts and byte or halfword sign extension.

The operands come in one of two forms. In the immediate form, the rotate amount and the end-mask length come from instruction fields. In the register form, the rotate amount comes from a rotate register. When the end-mask field is nonzero, the end-mask length comes from the register that follows the source register. The execution pipeline presents the operands with a one-cycle valid strobe. One clock later the unit returns the new destination word with a write-enable, or it raises an error flag when the register pairing is illegal.

Top module: `rmm_shift_unit`

## Requirements
- R1: With `dirRight`=0 the source rotates left by the rotate amount, and the effective count N equals that amount. With `dirRight`=1 the source rotates right by the amount, and N = (32 - amount) mod 32.
- R2: An end-mask length E of 0 gives an all-ones end-mask. A length E in 1..31 gives a mask with bits E-1..0 set. When `invEnd`=1 the end-mask is complemented after it is formed.
- R3: The `mergeCode` selects the shift-mask. Codes 0, 1 and 2 give all ones. Codes 3, 4 and 5 give the low N bits set (none when N=0). Codes 6 and 7 give the complement of that low-N mask. The composite mask is the shift-mask ANDed with the end-mask.
- R4: Codes 0, 3 and 6 produce the rotated word ANDed with the composite mask, with every other bit zero.
- R5: Codes 1, 4 and 7 take each bit from the rotated word where the composite mask is 1, and from `dstOld` where it is 0.
- R6: Codes 2 and 5 first form the masked rotated word. Then, taking bits 1 to 31 in ascending order, each bit whose composite-mask bit is 0 copies the bit below it, so the fill cascades upward.
- R7: With `regForm`=1, the rotate amount is `rotReg[4:0]` and `rotAmt` is ignored. The end-mask length is 0 when `endField` is 0, and `pairWord[4:0]` otherwise.
- R8: With `regForm`=1, a nonzero `endField` and an odd `srcIndex`, the request is illegal. `errFlag` is 1 in the following cycle, `wrEn` stays 0 and `resultWord` keeps its previous value.
- R9: For a legal request, `resultWord` and `wrEn`=1 appear one clock after `inValid`, with `errFlag`=0. In a cycle after one without `inValid`, both `wrEn` and `errFlag` are 0.
- R10: Synchronous active-high `rst` clears `resultWord`, `wrEn` and `errFlag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe, one cycle per operation |
| srcWord | input | 32 | Source operand to rotate |
| dstOld | input | 32 | Current destination value, used by keep codes |
| rotAmt | input | 5 | Rotate amount in the immediate form |
| dirRight | input | 1 | 1 = rotate right, 0 = rotate left |
| endField | input | 5 | End-mask length field (immediate form) or enable of the pair operand (register form) |
| invEnd | input | 1 | Complement the end-mask |
| mergeCode | input | 3 | Shift-mask and fill selection code |
| regForm | input | 1 | 1 = register-sourced rotate amount and end-mask length |
| srcIndex | input | 5 | Register index of the source, checked for evenness |
| rotReg | input | 32 | Rotate register value (register form) |
| pairWord | input | 32 | Value of the register after the source (register form) |
| wrEn | output | 1 | Destination write-enable, one cycle |
| resultWord | output | 32 | New destination word |
| errFlag | output | 1 | Illegal register pairing, one cycle |

## Verification
A vector table drives hand-worked cases that each isolate one decision. Left and right rotation with the masks open shows the direction and count mapping. Nonzero and inverted end lengths show the end-mask. The code groups at N=0 show the empty and full shift-masks. Byte sign extension and a right arithmetic shift show the sign cascade, and an insert under a mask shows the keep path. A sweep over all eight codes, several rotate amounts, both directions, two end lengths and both invert settings is compared against a bit-by-bit model written from the requirements. Directed steps then check register-form selection with a misleading immediate amount, the odd-index error with the held result, an odd index that is legal because the end field is zero, the idle cycle and reset.

// File: rtl/rmm_pkg.sv
package rmm_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned IDX_W = 5;
  localparam int unsigned CNT_W = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {FILL_ZERO = 2'd0, FILL_KEEP = 2'd1, FILL_SIGN = 2'd2} fill_e;
  typedef enum logic [1:0] {SM_OFF = 2'd0, SM_LOW = 2'd1, SM_HIGH = 2'd2} smask_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic fault;
  } strobe_t;

  // resolved operands for the mask and merge logic
  typedef struct packed {
    cnt_t   rotN;
    cnt_t   endLen;
    logic   endInv;
    fill_e  fill;
    smask_e smode;
  } opsel_t;

  function automatic fill_e fillOf(input logic [2:0] code);
    case (code)
      3'd0, 3'd3, 3'd6: fillOf = FILL_ZERO;
      3'd1, 3'd4, 3'd7: fillOf = FILL_KEEP;
      default:          fillOf = FILL_SIGN;
    endcase
  endfunction

  function automatic smask_e smodeOf(input logic [2:0] code);
    if (code < 3'd3)      smodeOf = SM_OFF;
    else if (code < 3'd6) smodeOf = SM_LOW;
    else                  smodeOf = SM_HIGH;
  endfunction
endpackage

// File: rtl/rmm_ctrl.sv
module rmm_ctrl
  import rmm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  cnt_t             rotAmt,
  input  logic             dirRight,
  input  cnt_t             endField,
  input  logic             invEnd,
  input  logic [2:0]       mergeCode,
  input  logic             regForm,
  input  logic [IDX_W-1:0] srcIndex,
  input  word_t            rotReg,
  input  word_t            pairWord,
  output strobe_t          stb,
  output opsel_t           ops,
  output logic             wrEn,
  output logic             errFlag
);
  cnt_t rotSel;
  logic endNonZero;
  logic unusedHigh;

  assign unusedHigh = ^{rotReg[WORD_W-1:CNT_W], pairWord[WORD_W-1:CNT_W], srcIndex[IDX_W-1:1]};
  assign endNonZero = |endField;

  always_comb begin
    rotSel = regForm ? rotReg[CNT_W-1:0] : rotAmt;
    ops.rotN = dirRight ? cnt_t'(~rotSel + 1'b1) : rotSel;
    if (regForm)
      ops.endLen = endNonZero ? pairWord[CNT_W-1:0] : '0;
    else
      ops.endLen = endField;
    ops.endInv = invEnd;
    ops.fill   = fillOf(mergeCode);
    ops.smode  = smodeOf(mergeCode);
  end

  always_comb begin
    stb.fault   = inValid && regForm && endNonZero && srcIndex[0];
    stb.capture = inValid && !stb.fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      wrEn    <= stb.capture;
      errFlag <= stb.fault;
    end
  end
endmodule

// File: rtl/rmm_mask_gen.sv
module rmm_mask_gen
  import rmm_pkg::*;
(
  input  opsel_t ops,
  output word_t  compMask
);
  word_t lowN;
  word_t endMask;
  word_t shiftMask;

  always_comb begin
    lowN = ~({WORD_W{1'b1}} << ops.rotN);
    if (ops.endLen == '0)
      endMask = '1;
    else
      endMask = ~({WORD_W{1'b1}} << ops.endLen);
    if (ops.endInv)
      endMask = ~endMask;
    case (ops.smode)
      SM_LOW:  shiftMask = lowN;
      SM_HIGH: shiftMask = ~lowN;
      default: shiftMask = '1;
    endcase
    compMask = shiftMask & endMask;
  end
endmodule

// File: rtl/rmm_sign_chain.sv
module rmm_sign_chain
  import rmm_pkg::*;
(
  input  word_t base,
  input  word_t compMask,
  output word_t filled
);
  // ordered prefix: each unmasked bit inherits the already-filled bit below
  always_comb begin
    filled = base;
    for (int b = 1; b < WORD_W; b++) begin
      if (!compMask[b])
        filled[b] = filled[b-1];
    end
  end
endmodule

// File: rtl/rmm_datapath.sv
module rmm_datapath
  import rmm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  opsel_t  ops,
  input  word_t   srcWord,
  input  word_t   dstOld,
  output word_t   resultWord
);
  logic [2*WORD_W-1:0] doubled;
  word_t rotated;
  word_t compMask;
  word_t masked;
  word_t signFilled;
  word_t nextWord;

  // right by R equals left by the negated count already held in rotN
  assign doubled = {srcWord, srcWord} << ops.rotN;
  assign rotated = doubled[2*WORD_W-1:WORD_W];
  assign masked  = rotated & compMask;

  rmm_mask_gen u_mask (
    .ops      (ops),
    .compMask (compMask)
  );

  rmm_sign_chain u_sign (
    .base     (masked),
    .compMask (compMask),
    .filled   (signFilled)
  );

  always_comb begin
    case (ops.fill)
      FILL_KEEP: nextWord = masked | (dstOld & ~compMask);
      FILL_SIGN: nextWord = signFilled;
      default:   nextWord = masked;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      resultWord <= '0;
    else if (stb.capture)
      resultWord <= nextWord;
  end
endmodule

// File: rtl/rmm_shift_unit.sv
module rmm_shift_unit
  import rmm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] srcWord,
  input  logic [31:0] dstOld,
  input  logic [4:0]  rotAmt,
  input  logic        dirRight,
  input  logic [4:0]  endField,
  input  logic        invEnd,
  input  logic [2:0]  mergeCode,
  input  logic        regForm,
  input  logic [4:0]  srcIndex,
  input  logic [31:0] rotReg,
  input  logic [31:0] pairWord,
  output logic        wrEn,
  output logic [31:0] resultWord,
  output logic        errFlag
);
  strobe_t stb;
  opsel_t  ops;

  rmm_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .rotAmt    (rotAmt),
    .dirRight  (dirRight),
    .endField  (endField),
    .invEnd    (invEnd),
    .mergeCode (mergeCode),
    .regForm   (regForm),
    .srcIndex  (srcIndex),
    .rotReg    (rotReg),
    .pairWord  (pairWord),
    .stb       (stb),
    .ops       (ops),
    .wrEn      (wrEn),
    .errFlag   (errFlag)
  );

  rmm_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .ops        (ops),
    .srcWord    (srcWord),
    .dstOld     (dstOld),
    .resultWord (resultWord)
  );
endmodule

// File: rtl/rmm_shift_checker.sv
module rmm_shift_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [31:0] dstOld,
  input logic [4:0]  rotAmt,
  input logic [4:0]  endField,
  input logic [2:0]  mergeCode,
  input logic        regForm,
  input logic        srcOdd,
  input logic        wrEn,
  input logic [31:0] resultWord,
  input logic        errFlag
);
  logic illegal;
  assign illegal = regForm && (endField != 5'd0) && srcOdd;

  p_empty_shiftmask_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && !regForm && mergeCode == 3'd3 && rotAmt == 5'd0) |=> resultWord == 32'd0);

  p_keep_all_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && !regForm && mergeCode == 3'd4 && rotAmt == 5'd0) |=> resultWord == $past(dstOld));

  p_sign_from_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && !regForm && mergeCode == 3'd5 && rotAmt == 5'd0) |=> resultWord == 32'd0);

  p_odd_pair_error_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && illegal) |=> (errFlag && !wrEn));

  p_hold_on_error_r8: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> $stable(resultWord));

  p_one_cycle_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (inValid && !illegal) |=> (wrEn && !errFlag));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!wrEn && !errFlag));

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (resultWord == 32'd0 && !wrEn && !errFlag));
endmodule

bind rmm_shift_unit rmm_shift_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .dstOld     (dstOld),
  .rotAmt     (rotAmt),
  .endField   (endField),
  .mergeCode  (mergeCode),
  .regForm    (regForm),
  .srcOdd     (srcIndex[0]),
  .wrEn       (wrEn),
  .resultWord (resultWord),
  .errFlag    (errFlag)
);

// File: tb/sim_rmm_shift_unit.sv
`timescale 1ns/1ps
module sim_rmm_shift_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [31:0] srcWord = '0, dstOld = '0, rotReg = '0, pairWord = '0;
  logic [4:0] rotAmt = '0, endField = '0, srcIndex = '0;
  logic dirRight = 1'b0, invEnd = 1'b0, regForm = 1'b0;
  logic [2:0] mergeCode = '0;
  logic wrEn, errFlag;
  logic [31:0] resultWord;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rmm_shift_unit u0 (.*);

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [4:0]  rot;
    logic        dir;
    logic [4:0]  endf;
    logic        inv;
    logic [2:0]  code;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h000000FF, 32'h0, 5'd8,  1'b0, 5'd0,  1'b0, 3'd0, 32'h0000FF00, 4'd1}, // R1 left
    '{32'h80000001, 32'h0, 5'd4,  1'b1, 5'd0,  1'b0, 3'd0, 32'h18000000, 4'd1}, // R1 right
    '{32'h00000080, 32'h0, 5'd0,  1'b0, 5'd8,  1'b0, 3'd2, 32'hFFFFFF80, 4'd6}, // R6 byte sign
    '{32'h80000000, 32'h0, 5'd4,  1'b1, 5'd0,  1'b0, 3'd5, 32'hF8000000, 4'd6}, // R6 arith right
    '{32'h0000000F, 32'h12345678, 5'd4, 1'b0, 5'd0, 1'b0, 3'd4, 32'h12345670, 4'd5}, // R5 keep
    '{32'hDEADBEEF, 32'h0, 5'd0,  1'b0, 5'd0,  1'b0, 3'd6, 32'hDEADBEEF, 4'd3}, // R3 full inverse
    '{32'hDEADBEEF, 32'h0, 5'd0,  1'b0, 5'd0,  1'b0, 3'd3, 32'h00000000, 4'd3}, // R3 empty
    '{32'hFFFFFFFF, 32'h0, 5'd0,  1'b0, 5'd4,  1'b1, 3'd0, 32'hFFFFFFF0, 4'd2}, // R2 invert
    '{32'h0000000F, 32'hAAAAAAAA, 5'd4, 1'b1, 5'd0, 1'b0, 3'd7, 32'hFAAAAAAA, 4'd5}, // R5 high mask
    '{32'h12345678, 32'hFFFFFFFF, 5'd16, 1'b0, 5'd16, 1'b0, 3'd1, 32'hFFFF1234, 4'd2}  // R2 low 16
  };

  function automatic logic [31:0] refModel(input logic [31:0] s, input logic [31:0] d,
      input int rot, input bit dir, input int endv, input bit inv, input int code);
    int n;
    logic [31:0] r, em, sm, cm, o;
    n = dir ? ((32 - rot) % 32) : rot;
    for (int i = 0; i < 32; i++) r[(i + n) % 32] = s[i];
    for (int i = 0; i < 32; i++) em[i] = (endv == 0) ? 1'b1 : (i < endv);
    if (inv) em = ~em;
    for (int i = 0; i < 32; i++)
      sm[i] = (code < 3) ? 1'b1 : ((code < 6) ? (i < n) : !(i < n));
    cm = sm & em;
    o = '0;
    for (int i = 0; i < 32; i++) begin
      if (code == 0 || code == 3 || code == 6) o[i] = r[i] & cm[i];
      else if (code == 1 || code == 4 || code == 7) o[i] = cm[i] ? r[i] : d[i];
      else if (i == 0 || cm[i]) o[i] = r[i] & cm[i];
      else o[i] = o[i-1];
    end
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // drive at a falling edge, result sampled at the next falling edge
  task automatic issue(input logic [31:0] s, input logic [31:0] d, input logic [4:0] rot,
      input logic dir, input logic [4:0] endf, input logic inv, input logic [2:0] code);
    @(negedge clk);
    srcWord = s; dstOld = d; rotAmt = rot; dirRight = dir;
    endField = endf; invEnd = inv; mergeCode = code; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R10 reset result", resultWord, 32'h0);
    chk("R10 reset wrEn", {31'h0, wrEn}, 32'h0);
    chk("R10 reset errFlag", {31'h0, errFlag}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      issue(VECS[k].src, VECS[k].dst, VECS[k].rot, VECS[k].dir,
            VECS[k].endf, VECS[k].inv, VECS[k].code);
      chk($sformatf("R%0d table row %0d", VECS[k].req, k), resultWord, VECS[k].expv);
      chk($sformatf("R9 table row %0d wrEn", k), {31'h0, wrEn}, 32'h1);
    end

    // R4 R5 R6 R1 R2 R3 sweep against bit-level model
    seed = 32'h1ACE5EED;
    for (int code = 0; code < 8; code++)
      for (int ri = 0; ri < 4; ri++)
        for (int dir = 0; dir < 2; dir++)
          for (int ei = 0; ei < 2; ei++)
            for (int inv = 0; inv < 2; inv++) begin
              int rot;
              int endv;
              logic [31:0] d;
              rot  = (ri == 0) ? 0 : (ri == 1) ? 1 : (ri == 2) ? 13 : 31;
              endv = (ei == 0) ? 0 : 5;
              seed = seed * 32'd1664525 + 32'd1013904223;
              d = ~seed ^ 32'h5A5A0F0F;
              issue(seed, d, rot[4:0], dir[0], endv[4:0], inv[0], code[2:0]);
              chk($sformatf("R4/R5/R6 sweep code=%0d rot=%0d dir=%0d", code, rot, dir),
                  resultWord, refModel(seed, d, rot, dir[0], endv, inv[0], code));
            end

    // R7 register form: rotate from rotReg, end length from pairWord
    @(negedge clk);
    regForm = 1'b1; srcIndex = 5'd2; rotReg = 32'hFFFFFF24; pairWord = 32'h00000028;
    issue(32'h000000AB, 32'h0, 5'd9, 1'b0, 5'd1, 1'b0, 3'd0);
    chk("R7 register operands", resultWord, 32'h000000B0);
    // R7 end field zero: end-mask all ones, odd index is legal
    srcIndex = 5'd3;
    issue(32'h000000AB, 32'h0, 5'd9, 1'b0, 5'd0, 1'b0, 3'd0);
    chk("R7 zero end field", resultWord, 32'h00000AB0);
    chk("R8 odd index legal when end zero", {31'h0, errFlag}, 32'h0);
    held = resultWord;
    // R8 odd index with pair operand
    issue(32'hFFFFFFFF, 32'h0, 5'd0, 1'b0, 5'd1, 1'b0, 3'd0);
    chk("R8 errFlag raised", {31'h0, errFlag}, 32'h1);
    chk("R8 wrEn low", {31'h0, wrEn}, 32'h0);
    chk("R8 result held", resultWord, held);
    @(negedge clk);
    chk("R8 errFlag one cycle", {31'h0, errFlag}, 32'h0);
    chk("R9 idle wrEn", {31'h0, wrEn}, 32'h0);
    regForm = 1'b0; srcIndex = 5'd0;

    // R10 reset mid-run
    issue(32'h12345678, 32'h0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd0);
    chk("R4 before reset", resultWord, 32'h12345678);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset clears result", resultWord, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule